// File: doc/BRIEF.md
# Fractional Core Clock Divider with Pixel Clock Prescaler

This block derives two timing streams from a single source clock. The first stage is a core clock divider. It issues a one-cycle enable pulse every N source cycles. An optional fraction b/a stretches some periods by one source cycle, so that the average period is N + b/a. The second stage counts those core pulses and issues a pixel pulse every P core periods. It also drives a pixel clock pin level that flips on each pixel pulse while a transfer is active, and that rests at a programmable level otherwise.

A two-bit source select gates the whole chain. Code 0 switches the divider off. Codes 1, 2 and 3 name the crystal, the faster PLL tap and the slower PLL tap, and all three run the divider identically, because the source multiplexer sits outside this block. Divider settings are sampled only where a core period ends, and prescaler settings only where a pixel period ends, so the outputs never show a runt period. A launch flag marks the pixel pulses whose pin transition is on the edge chosen for data launch.

The core divider runs a two-state machine, with states CD_OFF and CD_RUN. CD_OFF goes to CD_RUN when the select is nonzero. CD_RUN goes back to CD_OFF at a period end where the select reads zero. The pixel stage also runs a two-state machine, with states PX_IDLE and PX_ACTIVE. PX_IDLE goes to PX_ACTIVE when the transfer input is high. PX_ACTIVE goes back to PX_IDLE at once when the transfer input drops.

Top module: `pixclk_gen`

## Requirements
- R1: While reset is asserted, core_tick_o, pix_tick_o and launch_o are 0 and pclk_o is 0.
- R2: With frac_den_i = 0 and int_div_i in 2..255, core_tick_o pulses high for one cycle every int_div_i source cycles.
- R3: An int_div_i value of 0 divides by 256, and a value of 1 is treated as 2.
- R4: With frac_den_i nonzero and frac_num_i < frac_den_i, an accumulator starting at 0 on each enable adds frac_num_i at every period boundary. When the sum reaches frac_den_i, the next period lasts one extra source cycle and frac_den_i is subtracted. Example: N=4, a=4, b=1 gives periods 4,4,4,5 repeating.
- R5: If frac_num_i >= frac_den_i with frac_den_i nonzero, the fraction is ignored and division is integer only.
- R6: A change to int_div_i, frac_den_i or frac_num_i leaves the period in progress at its old length; the new value applies from the next period.
- R7: src_sel_i = 0 stops core ticks after the period in progress completes (exactly one more tick). Codes 1, 2 and 3 all run the divider, and the first tick after an enable comes one full period after the divider starts.
- R8: While xfer_i is high, pix_tick_o pulses on every P-th core tick, where P = pre_cnt_i + 1, and it only ever coincides with a core tick.
- R9: pre_bypass_i = 1 gives P = 1, so a pixel tick comes on every core tick. pre_cnt_i = 0 without bypass is treated as P = 2.
- R10: pclk_o inverts on each pixel tick. While xfer_i is low, pclk_o follows idle_lvl_i one cycle later.
- R11: launch_o marks the pixel ticks on which pclk_o makes a rising transition (launch_fall_i = 0) or a falling transition (launch_fall_i = 1).
- R12: A change to pre_cnt_i or pre_bypass_i takes effect only at the next pixel boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 2 | 0 off, 1 crystal, 2 fast PLL tap, 3 slow PLL tap |
| int_div_i | input | 8 | Integer divide value (0 means 256) |
| frac_den_i | input | 6 | Fraction denominator a (0 disables the fraction) |
| frac_num_i | input | 6 | Fraction numerator b |
| pre_cnt_i | input | 6 | Pixel prescale count, P = value + 1 |
| pre_bypass_i | input | 1 | Force P = 1 |
| idle_lvl_i | input | 1 | pclk_o level when no transfer is active |
| launch_fall_i | input | 1 | 1: launch on falling pin edge, 0: on rising |
| xfer_i | input | 1 | Transfer active |
| core_tick_o | output | 1 | Core clock enable pulse |
| pix_tick_o | output | 1 | Pixel clock enable pulse |
| pclk_o | output | 1 | Pixel clock pin level |
| launch_o | output | 1 | Pixel tick on the selected launch edge |

## Verification
The divider is driven with a plain integer ratio, the two extreme integer fields (0 and 1), a fraction whose stretch pattern 4,4,4,5 exposes accumulator errors, and an illegal fraction that must collapse to integer spacing. Mid-period rewrites of the divider, and a disable issued between boundaries, show whether settings are sampled only at period ends. On the pixel side, prescale values with and without bypass, and the zero count, separate counter off-by-one errors. Idle levels are toggled with the transfer off, and both launch polarities are run, which distinguishes a wrong rest level from a wrong edge choice.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    typedef enum logic {
        CD_OFF,
        CD_RUN
    } core_state_e;

    typedef enum logic {
        PX_IDLE,
        PX_ACTIVE
    } pix_state_e;

    localparam logic [1:0] SRC_OFF  = 2'd0;
    localparam logic [1:0] SRC_XTAL = 2'd1;
    localparam logic [1:0] SRC_FAST = 2'd2;
    localparam logic [1:0] SRC_SLOW = 2'd3;

endpackage

// File: rtl/pcg_core_div.sv
module pcg_core_div
    import pcg_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        src_sel_i,
    input  logic [INT_W-1:0]  int_div_i,
    input  logic [FRAC_W-1:0] frac_den_i,
    input  logic [FRAC_W-1:0] frac_num_i,
    output logic              core_tick_o
);
    localparam int LEN_W = INT_W + 1;
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(1) << INT_W;

    core_state_e       state_q, state_d;
    logic [LEN_W-1:0]  cnt_q, cnt_d, len_q, len_d;
    logic [LEN_W-1:0]  base_len, plan_len;
    logic [FRAC_W-1:0] acc_q, acc_d, plan_acc;
    logic [FRAC_W:0]   frac_sum;
    logic              frac_on, period_end, src_on;

    // integer part: field 0 selects the full range, field 1 is clamped
    always_comb begin
        if (int_div_i == '0) begin
            base_len = FULL_LEN;
        end else if (int_div_i == INT_W'(1)) begin
            base_len = LEN_W'(2);
        end else begin
            base_len = {1'b0, int_div_i};
        end
    end

    // length of the period about to begin, from the accumulator
    always_comb begin
        frac_on  = (frac_den_i != '0) && (frac_num_i < frac_den_i);
        frac_sum = {1'b0, acc_q} + {1'b0, frac_num_i};
        if (frac_on && (frac_sum >= {1'b0, frac_den_i})) begin
            plan_len = base_len + LEN_W'(1);
            plan_acc = FRAC_W'(frac_sum - {1'b0, frac_den_i});
        end else begin
            plan_len = base_len;
            plan_acc = frac_on ? frac_sum[FRAC_W-1:0] : '0;
        end
    end

    assign src_on     = (src_sel_i != SRC_OFF);
    assign period_end = (state_q == CD_RUN) && (cnt_q == len_q - LEN_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        len_d   = len_q;
        acc_d   = acc_q;
        unique case (state_q)
            CD_OFF: begin
                if (src_on) begin
                    state_d = CD_RUN;
                    cnt_d   = '0;
                    len_d   = plan_len;
                    acc_d   = plan_acc;
                end
            end
            CD_RUN: begin
                if (period_end) begin
                    cnt_d = '0;
                    if (!src_on) begin
                        state_d = CD_OFF;
                        acc_d   = '0;
                    end else begin
                        len_d = plan_len;
                        acc_d = plan_acc;
                    end
                end else begin
                    cnt_d = cnt_q + LEN_W'(1);
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CD_OFF;
            cnt_q   <= '0;
            len_q   <= LEN_W'(2);
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            len_q   <= len_d;
            acc_q   <= acc_d;
        end
    end

    // outputs
    always_comb begin
        core_tick_o = period_end;
    end

    AST_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CD_RUN) |-> (len_q >= LEN_W'(2) && len_q <= FULL_LEN + LEN_W'(1))); // R3
    AST_HOLD_MIDPERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CD_RUN && !period_end) |=> $stable(len_q)); // R6
    AST_STRETCH_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_end && src_on) |=> (len_q == $past(base_len) || len_q == $past(base_len) + LEN_W'(1))); // R4
    AST_INT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_end && src_on && !frac_on) |=> (len_q == $past(base_len))); // R5
    AST_STOP_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == CD_RUN && !period_end) |=> (state_q == CD_RUN)); // R7

endmodule

// File: rtl/pcg_pix_scaler.sv
module pcg_pix_scaler
    import pcg_pkg::*;
#(
    parameter int PRE_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             core_tick_i,
    input  logic             xfer_i,
    input  logic [PRE_W-1:0] pre_cnt_i,
    input  logic             pre_bypass_i,
    input  logic             idle_lvl_i,
    input  logic             launch_fall_i,
    output logic             pix_tick_o,
    output logic             pclk_o,
    output logic             launch_o
);
    localparam int PLEN_W = PRE_W + 1;
    localparam logic [PLEN_W-1:0] MAX_PLEN = PLEN_W'(1) << PRE_W;

    pix_state_e        state_q, state_d;
    logic [PLEN_W-1:0] pcnt_q, pcnt_d, plen_q, plen_d, req_len;
    logic              pclk_q, pclk_d;
    logic              last_slot;

    // requested pixel period in core ticks
    always_comb begin
        if (pre_bypass_i) begin
            req_len = PLEN_W'(1);
        end else if (pre_cnt_i == '0) begin
            req_len = PLEN_W'(2);
        end else begin
            req_len = {1'b0, pre_cnt_i} + PLEN_W'(1);
        end
    end

    assign last_slot = (state_q == PX_ACTIVE) && xfer_i && core_tick_i &&
                       (pcnt_q == plen_q - PLEN_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        plen_d  = plen_q;
        pclk_d  = pclk_q;
        unique case (state_q)
            PX_IDLE: begin
                pclk_d = idle_lvl_i;
                pcnt_d = '0;
                if (xfer_i) begin
                    state_d = PX_ACTIVE;
                    plen_d  = req_len;
                end
            end
            PX_ACTIVE: begin
                if (!xfer_i) begin
                    state_d = PX_IDLE;
                    pclk_d  = idle_lvl_i;
                    pcnt_d  = '0;
                end else if (core_tick_i) begin
                    if (last_slot) begin
                        pclk_d = ~pclk_q;
                        pcnt_d = '0;
                        plen_d = req_len;
                    end else begin
                        pcnt_d = pcnt_q + PLEN_W'(1);
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PX_IDLE;
            pcnt_q  <= '0;
            plen_q  <= PLEN_W'(1);
            pclk_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
            plen_q  <= plen_d;
            pclk_q  <= pclk_d;
        end
    end

    // outputs
    always_comb begin
        pix_tick_o = last_slot;
        pclk_o     = pclk_q;
        launch_o   = last_slot && (pclk_q == launch_fall_i);
    end

    AST_PIX_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_tick_o |-> core_tick_i); // R8
    AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xfer_i |=> (pclk_o == $past(idle_lvl_i))); // R10
    AST_PCLK_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_tick_o |=> (pclk_o != $past(pclk_o))); // R10
    AST_LAUNCH_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        launch_o |=> (pclk_o == !$past(launch_fall_i))); // R11
    AST_PLEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PX_ACTIVE) |-> (plen_q >= PLEN_W'(1) && plen_q <= MAX_PLEN)); // R9
    AST_PLEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == PX_ACTIVE && xfer_i && !last_slot) |=> $stable(plen_q)); // R12

endmodule

// File: rtl/pixclk_gen.sv
module pixclk_gen #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 6,
    parameter int PRE_W  = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        src_sel_i,
    input  logic [INT_W-1:0]  int_div_i,
    input  logic [FRAC_W-1:0] frac_den_i,
    input  logic [FRAC_W-1:0] frac_num_i,
    input  logic [PRE_W-1:0]  pre_cnt_i,
    input  logic              pre_bypass_i,
    input  logic              idle_lvl_i,
    input  logic              launch_fall_i,
    input  logic              xfer_i,
    output logic              core_tick_o,
    output logic              pix_tick_o,
    output logic              pclk_o,
    output logic              launch_o
);
    logic core_tick;

    pcg_core_div #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_core_div (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .src_sel_i   (src_sel_i),
        .int_div_i   (int_div_i),
        .frac_den_i  (frac_den_i),
        .frac_num_i  (frac_num_i),
        .core_tick_o (core_tick)
    );

    pcg_pix_scaler #(
        .PRE_W (PRE_W)
    ) u_pix_scaler (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .core_tick_i   (core_tick),
        .xfer_i        (xfer_i),
        .pre_cnt_i     (pre_cnt_i),
        .pre_bypass_i  (pre_bypass_i),
        .idle_lvl_i    (idle_lvl_i),
        .launch_fall_i (launch_fall_i),
        .pix_tick_o    (pix_tick_o),
        .pclk_o        (pclk_o),
        .launch_o      (launch_o)
    );

    assign core_tick_o = core_tick;

endmodule

// File: tb/pixclk_gen_bench.sv
module pixclk_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic [7:0] nint = 8'd5;
    logic [5:0] den = 6'd0;
    logic [5:0] num = 6'd0;
    logic [5:0] pcnt = 6'd2;
    logic       byp = 1'b0;
    logic       idle = 1'b0;
    logic       fall = 1'b0;
    logic       xfer = 1'b0;
    logic       core_tick, pix_tick, pclk, launch;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    int tick_q[$];
    int pix_q[$];

    // reference model state
    int  m_run, m_cnt, m_len, m_acc;
    int  p_act, p_cnt, p_len, p_clk;
    int  base, nl, na, s, plen_req;
    bit  frac, tick_now, last_now;
    bit  prev_launch, prev_fall;

    always #4 clk = ~clk; // 125 MHz

    pixclk_gen u_pixclk_gen (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .src_sel_i     (sel),
        .int_div_i     (nint),
        .frac_den_i    (den),
        .frac_num_i    (num),
        .pre_cnt_i     (pcnt),
        .pre_bypass_i  (byp),
        .idle_lvl_i    (idle),
        .launch_fall_i (fall),
        .xfer_i        (xfer),
        .core_tick_o   (core_tick),
        .pix_tick_o    (pix_tick),
        .pclk_o        (pclk),
        .launch_o      (launch)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_len = 2; m_acc = 0;
            p_act = 0; p_cnt = 0; p_len = 1; p_clk = 0;
        end else begin
            tick_now = (m_run != 0) && (m_cnt == m_len - 1);
            last_now = (p_act != 0) && xfer && tick_now && (p_cnt == p_len - 1);
            base = (nint == 0) ? 256 : ((nint == 1) ? 2 : int'(nint));
            frac = (den != 0) && (num < den);
            s = m_acc + int'(num);
            if (frac && s >= int'(den)) begin nl = base + 1; na = s - int'(den); end
            else begin nl = base; na = frac ? s : 0; end
            if (m_run == 0) begin
                if (sel != 0) begin m_run = 1; m_cnt = 0; m_len = nl; m_acc = na; end
            end else if (tick_now) begin
                m_cnt = 0;
                if (sel == 0) begin m_run = 0; m_acc = 0; end
                else begin m_len = nl; m_acc = na; end
            end else begin
                m_cnt++;
            end
            plen_req = byp ? 1 : ((pcnt == 0) ? 2 : int'(pcnt) + 1);
            if (p_act == 0) begin
                p_clk = int'(idle); p_cnt = 0;
                if (xfer) begin p_act = 1; p_len = plen_req; end
            end else if (!xfer) begin
                p_act = 0; p_clk = int'(idle); p_cnt = 0;
            end else if (tick_now) begin
                if (last_now) begin p_clk = 1 - p_clk; p_cnt = 0; p_len = plen_req; end
                else p_cnt++;
            end
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #2;
        cyc++;
        if (rst_n && !done) begin
            tick_now = (m_run != 0) && (m_cnt == m_len - 1);
            last_now = (p_act != 0) && xfer && tick_now && (p_cnt == p_len - 1);
            chk(core_tick == tick_now, "R2 R3 R4 R5 R6 R7 core_tick", int'(core_tick), int'(tick_now));
            chk(pix_tick == last_now, "R8 R9 R12 pix_tick", int'(pix_tick), int'(last_now));
            chk(int'(pclk) == p_clk, "R10 pclk", int'(pclk), p_clk);
            chk(launch == (last_now && (p_clk == int'(fall))), "R11 launch", int'(launch),
                int'(last_now && (p_clk == int'(fall))));
            if (prev_launch)
                chk(pclk == !prev_fall, "R11 edge after launch", int'(pclk), int'(!prev_fall));
            prev_launch = launch;
            prev_fall = fall;
            if (core_tick) tick_q.push_back(cyc);
            if (pix_tick) pix_q.push_back(cyc);
        end
    end

    task automatic wait_core(input int k);
        int start = tick_q.size();
        while (tick_q.size() < start + k) @(posedge clk);
    endtask

    task automatic wait_pix(input int k);
        int start = pix_q.size();
        while (pix_q.size() < start + k) @(posedge clk);
    endtask

    task automatic gap_chk(input string tag, input int exp);
        chk(tick_q[$] - tick_q[$-1] == exp, tag, tick_q[$] - tick_q[$-1], exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int st;
        prev_launch = 0;
        prev_fall = 0;
        repeat (3) @(negedge clk);
        chk(core_tick == 0, "R1 core_tick in reset", int'(core_tick), 0);
        chk(pix_tick == 0, "R1 pix_tick in reset", int'(pix_tick), 0);
        chk(launch == 0, "R1 launch in reset", int'(launch), 0);
        chk(pclk == 0, "R1 pclk in reset", int'(pclk), 0);
        rst_n = 1'b1;

        // integer division and pixel prescale
        @(negedge clk); xfer = 1; sel = 2'd1;
        wait_core(6);
        gap_chk("R2 integer gap", 5);
        wait_pix(3);
        chk(pix_q[$] - pix_q[$-1] == 15, "R8 pixel gap", pix_q[$] - pix_q[$-1], 15);

        // extreme integer fields
        @(negedge clk); nint = 8'd0;
        wait_core(3);
        gap_chk("R3 field zero", 256);
        @(negedge clk); nint = 8'd1;
        wait_core(3);
        gap_chk("R3 field one", 2);

        // fractional sequence from a fresh start
        @(negedge clk); sel = 2'd0;
        repeat (300) @(negedge clk);
        nint = 8'd4; den = 6'd4; num = 6'd1;
        st = tick_q.size();
        sel = 2'd1;
        wait_core(9);
        chk(tick_q[st+1] - tick_q[st] == 4, "R4 gap one", tick_q[st+1] - tick_q[st], 4);
        chk(tick_q[st+2] - tick_q[st+1] == 4, "R4 gap two", tick_q[st+2] - tick_q[st+1], 4);
        chk(tick_q[st+3] - tick_q[st+2] == 5, "R4 gap three", tick_q[st+3] - tick_q[st+2], 5);
        for (int k = 0; k < 4; k++)
            chk(tick_q[st+k+4] - tick_q[st+k] == 17, "R4 four-period sum",
                tick_q[st+k+4] - tick_q[st+k], 17);

        // illegal fraction collapses to integer
        @(negedge clk); nint = 8'd5; den = 6'd3; num = 6'd5;
        wait_core(2);
        wait_core(6);
        chk(tick_q[$] - tick_q[$-6] == 30, "R5 integer only", tick_q[$] - tick_q[$-6], 30);

        // mid-period rewrite
        @(negedge clk); nint = 8'd10; den = 6'd0; num = 6'd0;
        wait_core(3);
        st = tick_q.size();
        wait_core(1);
        repeat (3) @(negedge clk);
        nint = 8'd3;
        wait_core(2);
        chk(tick_q[st+1] - tick_q[st] == 10, "R6 old length kept", tick_q[st+1] - tick_q[st], 10);
        chk(tick_q[st+2] - tick_q[st+1] == 3, "R6 new length", tick_q[st+2] - tick_q[st+1], 3);

        // disable at boundary, then other source codes
        @(negedge clk); nint = 8'd6;
        wait_core(2);
        st = tick_q.size();
        repeat (2) @(negedge clk);
        sel = 2'd0;
        repeat (100) @(negedge clk);
        chk(tick_q.size() == st + 1, "R7 one tick after disable", tick_q.size() - st, 1);
        sel = 2'd2;
        wait_core(2);
        gap_chk("R7 code two runs", 6);
        @(negedge clk); sel = 2'd3;
        wait_core(2);
        gap_chk("R7 code three runs", 6);

        // bypass and zero count
        @(negedge clk); nint = 8'd2; byp = 1;
        wait_pix(3);
        chk(pix_q[$] - pix_q[$-1] == 2, "R9 bypass", pix_q[$] - pix_q[$-1], 2);
        @(negedge clk); byp = 0; pcnt = 6'd0;
        wait_pix(3);
        chk(pix_q[$] - pix_q[$-1] == 4, "R9 zero count", pix_q[$] - pix_q[$-1], 4);

        // idle level with transfer off
        @(negedge clk); xfer = 0; idle = 1;
        repeat (2) @(negedge clk);
        chk(pclk == 1, "R10 idle high", int'(pclk), 1);
        idle = 0;
        repeat (2) @(negedge clk);
        chk(pclk == 0, "R10 idle low", int'(pclk), 0);

        // falling launch edge, then prescale change while running
        idle = 1; fall = 1; xfer = 1; pcnt = 6'd1;
        wait_pix(4);
        @(negedge clk); pcnt = 6'd4;
        wait_pix(3);
        chk(pix_q[$] - pix_q[$-1] == 10, "R12 new prescale", pix_q[$] - pix_q[$-1], 10);
        repeat (20) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule